// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is the register front end of a device that lets several hosts share one memory region and signal each other. A 32-bit register bus reaches four word registers inside a 256-byte window. They are an interrupt enable mask, an interrupt status word, the read-only identity of this node and a write-only doorbell. The block drives a level interrupt line from the masked status. Status is cleared when software reads it and can also be loaded by a write.

A doorbell write packs a destination node and a vector number into one word. The block checks both fields against a small table of how many vectors each peer has registered. The table is filled through a side load port. A doorbell that passes the check leaves the block as a one-cycle notify pulse carrying the destination and the vector. A doorbell that fails is dropped with no trace. Event pulses aimed at this node set the status word when the block runs in legacy pin mode. In message-signalled mode they leave it alone.

Top module: `dbell_regblk`

## Requirements
- R1: Reset (asynchronous, active low) clears mask, status, the vector table, the notify output and the read data. The interrupt line is low afterwards.
- R2: A write whose word index (address bits 7:2) is 0 loads the mask. Address bits 1:0 are ignored on writes. A read at byte address 0 returns the mask.
- R3: A write at word index 1 loads the status with the written value as is, so bits can be set and cleared.
- R4: A read at byte address 4 returns the status and clears it to zero at the same clock edge. If a status write falls in the same cycle, the write wins over the clear.
- R5: The interrupt line is high exactly when message-signalled mode is off, the pin enable is on, and status AND mask is nonzero. It follows the registered values with no further delay.
- R6: A read at byte address 8 returns the node identity input, zero-extended. Writes there have no effect on any register.
- R7: A doorbell write (word index 3) takes the destination from data bits 31:16 and the vector from bits 7:0. Bits 15:8 are ignored. If the write is accepted, notify is high for exactly the next cycle with those two fields.
- R8: A doorbell is dropped, with no notify, when the destination is not below the peer count (the count is limited to the table size), or when the vector is not below that peer's table entry.
- R9: Reads return zero at byte address 12, at any address of 16 or more, at any address with bits 1:0 nonzero, and in every cycle without a read request.
- R10: In legacy mode, a local event pulse sets status to exactly 1 at the next edge. This overrides a status write or read-clear in the same cycle. In message-signalled mode the event leaves status unchanged.
- R11: Read data for a request in cycle t is presented in cycle t+1.
- R12: A table load writes one peer's vector count. A doorbell in the same cycle is checked against the old count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address within the register window |
| bus_wr | input | 1 | Write request |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| node_id | input | 16 | Identity of this node |
| msi_mode | input | 1 | 1: message-signalled mode, interrupt line unused |
| pin_en | input | 1 | Legacy interrupt pin enabled |
| peer_cnt | input | 5 | Number of known peers |
| tbl_ld | input | 1 | Load one vector-table entry |
| tbl_idx | input | 4 | Peer index to load |
| tbl_cnt | input | 8 | Vector count to store |
| evt_in | input | 1 | Event pulse for this node |
| irq_o | output | 1 | Level interrupt |
| ntf_valid | output | 1 | One-cycle doorbell notify |
| ntf_dest | output | 16 | Notify destination node |
| ntf_vec | output | 8 | Notify vector |

## Verification
The sharpest overlap is a local event landing in the same cycle as a status access. Two cases are covered: an event alongside a status read that clears, and an event alongside a status write. The bench drives the event pulse and the status access in one cycle. It expects the read to return the old value and expects the status to settle at 1, and it then reads the status back to confirm. A table load in the same cycle as a doorbell to that peer is also provoked, and it is judged by whether a notify pulse appears under the old count.

// File: rtl/dbell_pkg.sv
package dbell_pkg;

  // Word indices inside the register window (address bits above the byte lane)
  localparam int unsigned WIDX_MASK = 0;
  localparam int unsigned WIDX_STAT = 1;
  localparam int unsigned WIDX_NODE = 2;
  localparam int unsigned WIDX_BELL = 3;

  // Doorbell word layout
  localparam int unsigned BELL_DEST_LSB = 16;
  localparam int unsigned BELL_VEC_W    = 8;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_MASK = 2'd1,
    RSEL_STAT = 2'd2,
    RSEL_NODE = 2'd3
  } rsel_e;

endpackage

// File: rtl/dbell_decode.sv
module dbell_decode
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_mask,
  output logic              wr_stat,
  output logic              wr_bell,
  output logic              rd_stat,
  output rsel_e             rsel
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] widx;
  logic              aligned;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  // Writes decode on the word index only
  always_comb begin
    wr_mask = wr && (widx == WORD_W'(WIDX_MASK));
    wr_stat = wr && (widx == WORD_W'(WIDX_STAT));
    wr_bell = wr && (widx == WORD_W'(WIDX_BELL));
  end

  // Reads need an aligned address
  always_comb begin
    rsel = RSEL_NONE;
    if (rd && aligned) begin
      if (widx == WORD_W'(WIDX_MASK))      rsel = RSEL_MASK;
      else if (widx == WORD_W'(WIDX_STAT)) rsel = RSEL_STAT;
      else if (widx == WORD_W'(WIDX_NODE)) rsel = RSEL_NODE;
      else                                 rsel = RSEL_NONE;
    end
  end

  assign rd_stat = (rsel == RSEL_STAT);

endmodule

// File: rtl/dbell_irqstat.sv
module dbell_irqstat #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mask,
  input  logic              wr_stat,
  input  logic              rd_stat,
  input  logic [DATA_W-1:0] wdata,
  input  logic              evt_in,
  input  logic              msi_mode,
  input  logic              pin_en,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] stat_q,
  output logic              irq_o
);

  logic [DATA_W-1:0] stat_d;
  logic              stat_en;
  logic              evt_set;
  logic              legacy_pin;

  assign legacy_pin = !msi_mode && pin_en;
  assign evt_set    = evt_in && !msi_mode;

  // Status next state: write beats clear-on-read, a local event beats both
  always_comb begin
    stat_d = stat_q;
    if (wr_stat)      stat_d = wdata;
    else if (rd_stat) stat_d = '0;
    if (evt_set)      stat_d = DATA_W'(1);
  end

  assign stat_en = wr_stat || rd_stat || evt_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  assign irq_o = legacy_pin && (|(stat_q & mask_q));

endmodule

// File: rtl/dbell_vectab.sv
module dbell_vectab #(
  parameter int unsigned PEERS  = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DEST_W = 16,
  parameter int unsigned VEC_W  = 8,
  localparam int unsigned IDX_W  = (PEERS > 1) ? $clog2(PEERS) : 1,
  localparam int unsigned PCNT_W = $clog2(PEERS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [CNT_W-1:0]  ld_cnt,
  input  logic [PCNT_W-1:0] peer_cnt,
  input  logic [DEST_W-1:0] dest,
  input  logic [VEC_W-1:0]  vec,
  output logic              hit
);

  logic [CNT_W-1:0]  cnt_q [PEERS];
  logic [PCNT_W-1:0] eff_peers;
  logic              peer_ok;
  logic [CNT_W-1:0]  sel_cnt;

  // One register per peer, each with its own load enable
  for (genvar g = 0; g < PEERS; g++) begin : g_entry
    logic ent_en;
    assign ent_en = ld_en && (ld_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q[g] <= '0;
      else if (ent_en) cnt_q[g] <= ld_cnt;
    end
  end

  always_comb begin
    eff_peers = peer_cnt;
    if (32'(peer_cnt) > PEERS) eff_peers = PCNT_W'(PEERS);
  end

  assign peer_ok = (32'(dest) < 32'(eff_peers));

  always_comb begin
    sel_cnt = '0;
    for (int i = 0; i < PEERS; i++) begin
      if (32'(dest) == i) sel_cnt = cnt_q[i];
    end
  end

  assign hit = peer_ok && (32'(vec) < 32'(sel_cnt));

endmodule

// File: rtl/dbell_regblk.sv
module dbell_regblk
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PEERS  = 16,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned ID_W   = 16,
  localparam int unsigned DEST_W = DATA_W - BELL_DEST_LSB,
  localparam int unsigned VEC_W  = BELL_VEC_W,
  localparam int unsigned IDX_W  = (PEERS > 1) ? $clog2(PEERS) : 1,
  localparam int unsigned PCNT_W = $clog2(PEERS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [ID_W-1:0]   node_id,
  input  logic              msi_mode,
  input  logic              pin_en,
  input  logic [PCNT_W-1:0] peer_cnt,
  input  logic              tbl_ld,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [CNT_W-1:0]  tbl_cnt,
  input  logic              evt_in,
  output logic              irq_o,
  output logic              ntf_valid,
  output logic [DEST_W-1:0] ntf_dest,
  output logic [VEC_W-1:0]  ntf_vec
);

  logic              wr_mask;
  logic              wr_stat;
  logic              wr_bell;
  logic              rd_stat;
  rsel_e             rsel;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] stat_q;
  logic [DEST_W-1:0] bell_dest;
  logic [VEC_W-1:0]  bell_vec;
  logic              bell_hit;
  logic [DATA_W-1:0] rdata_d;
  logic              ntf_d;

  dbell_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .rd      (bus_rd),
    .wr_mask (wr_mask),
    .wr_stat (wr_stat),
    .wr_bell (wr_bell),
    .rd_stat (rd_stat),
    .rsel    (rsel)
  );

  dbell_irqstat #(.DATA_W(DATA_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_mask  (wr_mask),
    .wr_stat  (wr_stat),
    .rd_stat  (rd_stat),
    .wdata    (bus_wdata),
    .evt_in   (evt_in),
    .msi_mode (msi_mode),
    .pin_en   (pin_en),
    .mask_q   (mask_q),
    .stat_q   (stat_q),
    .irq_o    (irq_o)
  );

  assign bell_dest = bus_wdata[DATA_W-1:BELL_DEST_LSB];
  assign bell_vec  = bus_wdata[VEC_W-1:0];

  dbell_vectab #(
    .PEERS  (PEERS),
    .CNT_W  (CNT_W),
    .DEST_W (DEST_W),
    .VEC_W  (VEC_W)
  ) u_tab (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_en    (tbl_ld),
    .ld_idx   (tbl_idx),
    .ld_cnt   (tbl_cnt),
    .peer_cnt (peer_cnt),
    .dest     (bell_dest),
    .vec      (bell_vec),
    .hit      (bell_hit)
  );

  // Read data next state
  always_comb begin
    unique case (rsel)
      RSEL_MASK: rdata_d = mask_q;
      RSEL_STAT: rdata_d = stat_q;
      RSEL_NODE: rdata_d = DATA_W'(node_id);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rdata_d;
  end

  // Doorbell notify
  assign ntf_d = wr_bell && bell_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ntf_valid <= 1'b0;
    else        ntf_valid <= ntf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntf_dest <= '0;
      ntf_vec  <= '0;
    end else if (ntf_d) begin
      ntf_dest <= bell_dest;
      ntf_vec  <= bell_vec;
    end
  end

endmodule

// File: rtl/dbell_chk.sv
module dbell_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PCNT_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              msi_mode,
  input logic              evt_in,
  input logic [PCNT_W-1:0] peer_cnt,
  input logic              irq_o,
  input logic              ntf_valid,
  input logic [DATA_W-1:0] stat_q
);

  logic stat_wr_c;
  logic stat_rd_c;
  logic bell_wr_c;
  logic evt_c;

  assign stat_wr_c = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
  assign stat_rd_c = bus_rd && (bus_addr == ADDR_W'(4));
  assign bell_wr_c = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(3));
  assign evt_c     = evt_in && !msi_mode;

  // R3: a status write without a competing event lands as written
  p_stat_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_c && !evt_c) |=> (stat_q == $past(bus_wdata)));

  // R4: a clearing read with no write or event leaves the line low
  p_rd_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_c && !stat_wr_c && !evt_c) |=> !irq_o);

  // R5: message-signalled mode never raises the line
  p_msi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_mode |-> !irq_o);

  // R7: notify only follows a doorbell write
  p_ntf_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ntf_valid |-> $past(bell_wr_c));

  // R8: a destination outside the peer count is dropped
  p_drop_dest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bell_wr_c && (32'(bus_wdata[DATA_W-1:16]) >= 32'(peer_cnt))) |=> !ntf_valid);

  // R9: unmapped read offsets return zero
  p_unmapped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (bus_addr >= ADDR_W'(12))) |=> (bus_rdata == '0));

  // R10: a legacy local event leaves status at one
  p_evt_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_c |=> (stat_q == DATA_W'(1)));

endmodule

bind dbell_regblk dbell_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .PCNT_W (PCNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .msi_mode  (msi_mode),
  .evt_in    (evt_in),
  .peer_cnt  (peer_cnt),
  .irq_o     (irq_o),
  .ntf_valid (ntf_valid),
  .stat_q    (stat_q)
);

// File: tb/sim_dbell_regblk.sv
module sim_dbell_regblk;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_wr;
  logic [31:0] bus_wdata;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [15:0] node_id;
  logic        msi_mode;
  logic        pin_en;
  logic [4:0]  peer_cnt;
  logic        tbl_ld;
  logic [3:0]  tbl_idx;
  logic [7:0]  tbl_cnt;
  logic        evt_in;
  logic        irq_o;
  logic        ntf_valid;
  logic [15:0] ntf_dest;
  logic [7:0]  ntf_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  dbell_regblk u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .node_id   (node_id),
    .msi_mode  (msi_mode),
    .pin_en    (pin_en),
    .peer_cnt  (peer_cnt),
    .tbl_ld    (tbl_ld),
    .tbl_idx   (tbl_idx),
    .tbl_cnt   (tbl_cnt),
    .evt_in    (evt_in),
    .irq_o     (irq_o),
    .ntf_valid (ntf_valid),
    .ntf_dest  (ntf_dest),
    .ntf_vec   (ntf_vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int unsigned m_mask, m_stat, m_rd, m_dest, m_vec;
  bit          m_nv;
  int unsigned m_tbl [16];

  always @(posedge clk) begin
    int unsigned widx, dest, vec, npeer, nstat;
    if (!rst_n) begin
      m_mask = 0; m_stat = 0; m_rd = 0; m_nv = 0; m_dest = 0; m_vec = 0;
      for (int i = 0; i < 16; i++) m_tbl[i] = 0;
    end else begin
      widx  = bus_addr >> 2;
      dest  = bus_wdata >> 16;
      vec   = bus_wdata & 32'hFF;
      npeer = (peer_cnt > 16) ? 16 : peer_cnt;
      // read result
      m_rd = 0;
      if (bus_rd && bus_addr == 0) m_rd = m_mask;
      if (bus_rd && bus_addr == 4) m_rd = m_stat;
      if (bus_rd && bus_addr == 8) m_rd = node_id;
      // status
      nstat = m_stat;
      if (bus_wr && widx == 1) nstat = bus_wdata;
      else if (bus_rd && bus_addr == 4) nstat = 0;
      if (evt_in && !msi_mode) nstat = 1;
      // doorbell uses the table before this cycle's load
      m_nv = bus_wr && widx == 3 && dest < npeer && vec < m_tbl[dest];
      if (m_nv) begin m_dest = dest; m_vec = vec; end
      if (bus_wr && widx == 0) m_mask = bus_wdata;
      m_stat = nstat;
      if (tbl_ld) m_tbl[tbl_idx] = tbl_cnt;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      chk("R5 irq vs model", {31'd0, irq_o},
          {31'd0, (!msi_mode && pin_en && ((m_stat & m_mask) != 0))});
      chk("R11 rdata vs model", bus_rdata, m_rd);
      chk("R7 notify vs model", {31'd0, ntf_valid}, {31'd0, m_nv});
      if (m_nv) chk("R7 notify fields vs model", {8'd0, ntf_dest, ntf_vec},
                    {8'd0, m_dest[15:0], m_vec[7:0]});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    bus_wr = 0; bus_rd = 0; evt_in = 0; tbl_ld = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a; bus_rd = 1;
    @(posedge clk); @(negedge clk);
    idle();
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ld(input logic [3:0] i, input logic [7:0] c);
    tbl_idx = i; tbl_cnt = c; tbl_ld = 1;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  task automatic pulse_evt();
    evt_in = 1;
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    rst_n = 0; bus_addr = 0; bus_wdata = 0; node_id = 16'h00A5;
    msi_mode = 0; pin_en = 1; peer_cnt = 0; tbl_idx = 0; tbl_cnt = 0;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R1 notify after reset", {31'd0, ntf_valid}, 32'd0);
    chk("R1 rdata after reset", bus_rdata, 32'd0);
    rd(8'h00, 32'd0, "R1 mask after reset");
    rd(8'h04, 32'd0, "R1 status after reset");

    // mask, low address bits ignored on write
    wr(8'h01, 32'h0000_00FF);
    rd(8'h00, 32'h0000_00FF, "R2 mask write with low bits set");

    // status load and read-clear
    wr(8'h04, 32'h0000_0005);
    chk("R5 irq with masked status", {31'd0, irq_o}, 32'd1);
    rd(8'h04, 32'h0000_0005, "R3 status write value");
    chk("R4 irq low after clearing read", {31'd0, irq_o}, 32'd0);
    rd(8'h04, 32'd0, "R4 status cleared by read");

    // interrupt gating
    wr(8'h04, 32'h0000_0100);
    chk("R5 irq off when bits masked", {31'd0, irq_o}, 32'd0);
    msi_mode = 1;
    wr(8'h04, 32'h0000_0001);
    chk("R5 irq off in msi mode", {31'd0, irq_o}, 32'd0);
    msi_mode = 0; #1;
    chk("R5 irq on in legacy mode", {31'd0, irq_o}, 32'd1);
    pin_en = 0; #1;
    chk("R5 irq off with pin disabled", {31'd0, irq_o}, 32'd0);
    pin_en = 1;
    rd(8'h04, 32'h0000_0001, "R4 status read before clear");

    // node identity
    rd(8'h08, 32'h0000_00A5, "R6 node id");
    wr(8'h08, 32'hDEAD_BEEF);
    rd(8'h08, 32'h0000_00A5, "R6 node id unchanged by write");
    rd(8'h00, 32'h0000_00FF, "R6 mask unchanged by id write");
    rd(8'h04, 32'd0, "R6 status unchanged by id write");

    // unmapped reads
    rd(8'h0C, 32'd0, "R9 doorbell offset reads zero");
    rd(8'h40, 32'd0, "R9 high offset reads zero");
    rd(8'h02, 32'd0, "R9 unaligned read zero");
    rd(8'h05, 32'd0, "R9 unaligned status read zero");

    // doorbells
    ld(4'd0, 8'd2);
    ld(4'd3, 8'd1);
    peer_cnt = 5'd4;
    wr(8'h0C, 32'h0003_0000);
    chk("R7 notify valid", {31'd0, ntf_valid}, 32'd1);
    chk("R7 notify fields", {8'd0, ntf_dest, ntf_vec}, {8'd0, 16'h0003, 8'h00});
    @(negedge clk);
    chk("R7 notify single cycle", {31'd0, ntf_valid}, 32'd0);
    wr(8'h0C, 32'h0003_0001);
    chk("R8 vector out of range", {31'd0, ntf_valid}, 32'd0);
    wr(8'h0C, 32'h0004_0000);
    chk("R8 destination out of range", {31'd0, ntf_valid}, 32'd0);
    wr(8'h0C, 32'h0001_0000);
    chk("R8 peer with no vectors", {31'd0, ntf_valid}, 32'd0);
    wr(8'h0E, 32'h0000_FF01);
    chk("R7 doorbell low addr bits and mid bits ignored", {31'd0, ntf_valid}, 32'd1);
    chk("R7 notify fields second", {8'd0, ntf_dest, ntf_vec}, {8'd0, 16'h0000, 8'h01});
    peer_cnt = 5'd0;
    wr(8'h0C, 32'h0000_0000);
    chk("R8 no known peers", {31'd0, ntf_valid}, 32'd0);
    peer_cnt = 5'd16;

    // table load racing a doorbell to the same peer
    tbl_idx = 4'd3; tbl_cnt = 8'd0; tbl_ld = 1;
    bus_addr = 8'h0C; bus_wdata = 32'h0003_0000; bus_wr = 1;
    @(posedge clk); @(negedge clk);
    idle();
    chk("R12 doorbell sees old count", {31'd0, ntf_valid}, 32'd1);
    wr(8'h0C, 32'h0003_0000);
    chk("R12 new count applies next", {31'd0, ntf_valid}, 32'd0);

    // local events
    pulse_evt();
    rd(8'h04, 32'h0000_0001, "R10 legacy event sets status");
    msi_mode = 1;
    wr(8'h04, 32'h0000_0030);
    pulse_evt();
    msi_mode = 0;
    rd(8'h04, 32'h0000_0030, "R10 event ignored in msi mode");

    // collisions
    wr(8'h04, 32'h0000_0007);
    bus_addr = 8'h04; bus_rd = 1; evt_in = 1;
    @(posedge clk); @(negedge clk);
    idle();
    chk("R4 read with event returns old", bus_rdata, 32'h0000_0007);
    rd(8'h04, 32'h0000_0001, "R10 event survives clearing read");
    bus_addr = 8'h04; bus_wdata = 32'h0000_0030; bus_wr = 1; evt_in = 1;
    @(posedge clk); @(negedge clk);
    idle();
    rd(8'h04, 32'h0000_0001, "R10 event beats status write");
    bus_addr = 8'h04; bus_wdata = 32'h0000_0022; bus_wr = 1; bus_rd = 1;
    @(posedge clk); @(negedge clk);
    idle();
    rd(8'h04, 32'h0000_0022, "R4 write beats clear");

    // second reset
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(8'h00, 32'd0, "R1 mask after second reset");
    peer_cnt = 5'd16;
    wr(8'h0C, 32'h0000_0000);
    chk("R1 table cleared by reset", {31'd0, ntf_valid}, 32'd0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule